// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block runs the fixed memory sequence a processor core performs when it takes an interrupt or leaves a handler. At each instruction boundary, while idle, it looks at six possible causes: an internal exception, a software interrupt, a non-maskable request, a maskable request with its own 8-bit vector, a single-step trap, and a return-from-handler command. It picks one by a fixed ranking. For an interrupt it saves the flag word, the code segment and the instruction offset on the stack. It clears the interrupt-enable and trap flags, then fetches the handler's offset and segment from a 256-entry table of 4-byte slots at the bottom of memory. A one-cycle load strobe then hands the new program address, flag word and stack pointer to the core.

A return command reverses the stack work. It pops offset, segment and flags, and then presents them with the same load strobe. All memory traffic goes through one 16-bit request/acknowledge port. Each request is held until the memory acknowledges it, and stack addresses are formed as segment times 16 plus offset.

Top module: `int_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `load` and `ack` are 0.
- R2: Causes are sampled only while idle and only in a cycle with `boundary`=1. With `boundary`=0 no request is accepted and no memory access starts.
- R3: When several causes are present, the block picks one in this order: exception (vector `exc_vec`), then software (vector `swi_vec`), then non-maskable (vector 2), then maskable (vector `irq_vec`), then single-step trap (vector 1). The `ack` strobe goes high in the cycle after acceptance, and `ack_vec` shows the chosen vector.
- R4: A maskable request is ignored while bit 9 (interrupt enable) of `flags_in` is 0. A single-step trap is raised only when bit 8 (trap) of `flags_in` is 1.
- R5: Entry writes three words in this order: the flag word, then `cs_in`, then `ip_in`. The stack pointer is lowered by 2 before each write, so the writes land at SS*16+SP-2, SS*16+SP-4 and SS*16+SP-6. Each word is stored little-endian, low byte at the lower address.
- R6: After the pushes, entry reads the table slot for vector n: the offset from byte address 4n, then the segment from 4n+2.
- R7: At the end of entry, `load` is high for one cycle. At that point `new_ip` is the offset and `new_cs` is the segment read from the table. `new_flags` is the saved flag word with bits 9 and 8 cleared, and `new_sp` is SP-6. The block is idle in the next cycle.
- R8: A return command reads the offset at SS*16+SP, the segment at SS*16+SP+2 and the flag word at SS*16+SP+4. It then pulses `load` with those values and `new_sp`=SP+6.
- R9: Once `mem_req` is raised, it stays high with unchanged address, direction and write data until `mem_ack` is seen.
- R10: A return command has the lowest rank. If it arrives together with an accepted interrupt cause, the interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary; causes are sampled when high |
| exc_req | input | 1 | Internal exception request |
| exc_vec | input | 8 | Exception vector |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | 8 | Software interrupt vector |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | 1 | Maskable request |
| irq_vec | input | 8 | Maskable request vector |
| iret_req | input | 1 | Return-from-handler command |
| flags_in | input | 16 | Current flag word (bit 9 enable, bit 8 trap) |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction offset |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge; completes the access |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| ack | output | 1 | One-cycle strobe on interrupt acceptance |
| ack_vec | output | 8 | Accepted vector |
| load | output | 1 | One-cycle strobe: new state valid |
| new_ip | output | 16 | New instruction offset |
| new_cs | output | 16 | New code segment |
| new_flags | output | 16 | New flag word |
| new_sp | output | 16 | New stack pointer |

## Verification
The checker assumes that `mem_ack` is asserted only while `mem_req` is high, and for one cycle per access. It also assumes that request and flag inputs do not change between the sampling edge and the next cycle. The ranking and masking properties compare `ack` with inputs seen one cycle earlier, so they rely on this. The bench's memory model acknowledges one cycle after it sees a request and then drops the acknowledge. All stimulus is applied on the falling edge. Requests are withdrawn only after `busy` is seen, so every cause is either accepted on a sampled edge or held steady across it.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_F,
      ST_PUSH_CS,
      ST_PUSH_IP,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_POP_IP,
      ST_POP_CS,
      ST_POP_F,
      ST_DONE
   } seq_state_t;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_EXC,
      SRC_SWI,
      SRC_NMI,
      SRC_IRQ,
      SRC_TRAP,
      SRC_RET
   } src_t;

endpackage

// File: rtl/int_entry_arb.sv
module int_entry_arb
   import int_entry_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int NMI_VEC  = 2,
   parameter int TRAP_VEC = 1
) (
   input  logic             exc_req,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             swi_req,
   input  logic [VEC_W-1:0] swi_vec,
   input  logic             nmi_req,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             iret_req,
   input  logic             if_flag,
   input  logic             tf_flag,
   output src_t             sel,
   output logic [VEC_W-1:0] sel_vec
);

   localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
   localparam logic [VEC_W-1:0] TRAP_V = VEC_W'(TRAP_VEC);

   // fixed ranking: exception, software, non-maskable, maskable, trap, return
   always_comb begin
      sel     = SRC_NONE;
      sel_vec = '0;
      if (exc_req) begin
         sel     = SRC_EXC;
         sel_vec = exc_vec;
      end else if (swi_req) begin
         sel     = SRC_SWI;
         sel_vec = swi_vec;
      end else if (nmi_req) begin
         sel     = SRC_NMI;
         sel_vec = NMI_V;
      end else if (irq_req && if_flag) begin
         sel     = SRC_IRQ;
         sel_vec = irq_vec;
      end else if (tf_flag) begin
         sel     = SRC_TRAP;
         sel_vec = TRAP_V;
      end else if (iret_req) begin
         sel     = SRC_RET;
      end
   end

endmodule

// File: rtl/int_entry_beat.sv
module int_entry_beat
   import int_entry_pkg::*;
#(
   parameter int AW        = 20,
   parameter int DW        = 16,
   parameter int VEC_W     = 8,
   parameter bit SEGMENTED = 1'b1
) (
   input  seq_state_t       state,
   input  logic [DW-1:0]    ss,
   input  logic [DW-1:0]    sp,
   input  logic [VEC_W-1:0] vec,
   input  logic [DW-1:0]    flags,
   input  logic [DW-1:0]    cs,
   input  logic [DW-1:0]    ip,
   output logic             req,
   output logic             we,
   output logic [AW-1:0]    addr,
   output logic [DW-1:0]    wdata
);

   localparam int SLOT_SH = 2;   // 4 bytes per table slot
   localparam int WORD_B  = DW / 8;

   logic [DW-1:0] off;
   logic [AW-1:0] stack_addr;
   logic [AW-1:0] slot_base;

   assign slot_base = AW'(vec) << SLOT_SH;

   generate
      if (SEGMENTED) begin : g_seg
         assign stack_addr = AW'({ss, 4'b0000}) + AW'(off);
      end else begin : g_flat
         logic [DW-1:0] unused_ss;
         assign unused_ss  = ss;
         assign stack_addr = AW'(off);
      end
   endgenerate

   always_comb begin
      req   = 1'b0;
      we    = 1'b0;
      off   = sp;
      wdata = '0;
      addr  = stack_addr;
      unique case (state)
         ST_PUSH_F: begin
            req = 1'b1; we = 1'b1; off = sp - DW'(WORD_B); wdata = flags;
         end
         ST_PUSH_CS: begin
            req = 1'b1; we = 1'b1; off = sp - DW'(WORD_B); wdata = cs;
         end
         ST_PUSH_IP: begin
            req = 1'b1; we = 1'b1; off = sp - DW'(WORD_B); wdata = ip;
         end
         ST_VEC_LO: begin
            req = 1'b1; addr = slot_base;
         end
         ST_VEC_HI: begin
            req = 1'b1; addr = slot_base + AW'(WORD_B);
         end
         ST_POP_IP, ST_POP_CS, ST_POP_F: begin
            req = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
   import int_entry_pkg::*;
#(
   parameter int AW        = 20,
   parameter int DW        = 16,
   parameter int VEC_W     = 8,
   parameter int IF_BIT    = 9,
   parameter int TF_BIT    = 8,
   parameter int NMI_VEC   = 2,
   parameter int TRAP_VEC  = 1,
   parameter bit SEGMENTED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic             exc_req,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             swi_req,
   input  logic [VEC_W-1:0] swi_vec,
   input  logic             nmi_req,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             iret_req,
   input  logic [DW-1:0]    flags_in,
   input  logic [DW-1:0]    cs_in,
   input  logic [DW-1:0]    ip_in,
   input  logic [DW-1:0]    ss_in,
   input  logic [DW-1:0]    sp_in,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             busy,
   output logic             ack,
   output logic [VEC_W-1:0] ack_vec,
   output logic             load,
   output logic [DW-1:0]    new_ip,
   output logic [DW-1:0]    new_cs,
   output logic [DW-1:0]    new_flags,
   output logic [DW-1:0]    new_sp
);

   localparam int            WORD_B   = DW / 8;
   localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << IF_BIT) | (DW'(1) << TF_BIT));

   generate
      if (DW != 16) begin : g_bad_dw
         $error("int_entry_seq: word width must be 16");
      end
      if (AW < VEC_W + 2 || AW < DW) begin : g_bad_aw
         $error("int_entry_seq: address too narrow for table or stack");
      end
      if (IF_BIT >= DW || TF_BIT >= DW || IF_BIT == TF_BIT) begin : g_bad_bits
         $error("int_entry_seq: flag bit positions invalid");
      end
      if (NMI_VEC >= (1 << VEC_W) || TRAP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("int_entry_seq: fixed vector out of range");
      end
   endgenerate

   seq_state_t       state;
   src_t             sel;
   logic [VEC_W-1:0] sel_vec;
   logic [DW-1:0]    sp_q, ss_q, cs_q, ip_q, fl_q;
   logic [VEC_W-1:0] vec_q;

   int_entry_arb #(
      .VEC_W   (VEC_W),
      .NMI_VEC (NMI_VEC),
      .TRAP_VEC(TRAP_VEC)
   ) u_arb (
      .exc_req (exc_req),
      .exc_vec (exc_vec),
      .swi_req (swi_req),
      .swi_vec (swi_vec),
      .nmi_req (nmi_req),
      .irq_req (irq_req),
      .irq_vec (irq_vec),
      .iret_req(iret_req),
      .if_flag (flags_in[IF_BIT]),
      .tf_flag (flags_in[TF_BIT]),
      .sel     (sel),
      .sel_vec (sel_vec)
   );

   int_entry_beat #(
      .AW       (AW),
      .DW       (DW),
      .VEC_W    (VEC_W),
      .SEGMENTED(SEGMENTED)
   ) u_beat (
      .state(state),
      .ss   (ss_q),
      .sp   (sp_q),
      .vec  (vec_q),
      .flags(fl_q),
      .cs   (cs_q),
      .ip   (ip_q),
      .req  (mem_req),
      .we   (mem_we),
      .addr (mem_addr),
      .wdata(mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sp_q  <= '0;
         ss_q  <= '0;
         cs_q  <= '0;
         ip_q  <= '0;
         fl_q  <= '0;
         vec_q <= '0;
         ack   <= 1'b0;
      end else begin
         ack <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (boundary && sel != SRC_NONE) begin
                  sp_q  <= sp_in;
                  ss_q  <= ss_in;
                  cs_q  <= cs_in;
                  ip_q  <= ip_in;
                  fl_q  <= flags_in;
                  vec_q <= sel_vec;
                  if (sel == SRC_RET) begin
                     state <= ST_POP_IP;
                  end else begin
                     state <= ST_PUSH_F;
                     ack   <= 1'b1;
                  end
               end
            end
            ST_PUSH_F: if (mem_ack) begin
               sp_q  <= sp_q - DW'(WORD_B);
               state <= ST_PUSH_CS;
            end
            ST_PUSH_CS: if (mem_ack) begin
               sp_q  <= sp_q - DW'(WORD_B);
               state <= ST_PUSH_IP;
            end
            ST_PUSH_IP: if (mem_ack) begin
               sp_q  <= sp_q - DW'(WORD_B);
               fl_q  <= fl_q & CLR_MASK;
               state <= ST_VEC_LO;
            end
            ST_VEC_LO: if (mem_ack) begin
               ip_q  <= mem_rdata;
               state <= ST_VEC_HI;
            end
            ST_VEC_HI: if (mem_ack) begin
               cs_q  <= mem_rdata;
               state <= ST_DONE;
            end
            ST_POP_IP: if (mem_ack) begin
               ip_q  <= mem_rdata;
               sp_q  <= sp_q + DW'(WORD_B);
               state <= ST_POP_CS;
            end
            ST_POP_CS: if (mem_ack) begin
               cs_q  <= mem_rdata;
               sp_q  <= sp_q + DW'(WORD_B);
               state <= ST_POP_F;
            end
            ST_POP_F: if (mem_ack) begin
               fl_q  <= mem_rdata;
               sp_q  <= sp_q + DW'(WORD_B);
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign load      = (state == ST_DONE);
   assign ack_vec   = vec_q;
   assign new_ip    = ip_q;
   assign new_cs    = cs_q;
   assign new_flags = fl_q;
   assign new_sp    = sp_q;

endmodule

// File: rtl/int_entry_seq_chk.sv
module int_entry_seq_chk #(
   parameter int AW      = 20,
   parameter int DW      = 16,
   parameter int VEC_W   = 8,
   parameter int IF_BIT  = 9,
   parameter int TF_BIT  = 8,
   parameter int NMI_VEC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             boundary,
   input logic             exc_req,
   input logic             swi_req,
   input logic             nmi_req,
   input logic [DW-1:0]    flags_in,
   input logic             mem_req,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [DW-1:0]    mem_wdata,
   input logic             mem_ack,
   input logic             busy,
   input logic             ack,
   input logic [VEC_W-1:0] ack_vec,
   input logic             load
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !load && !ack)); // R1

   AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(boundary && !busy)); // R2

   AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(nmi_req && !exc_req && !swi_req)) |-> ack_vec == VEC_W'(NMI_VEC)); // R3

   AST_MASKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !$past(!exc_req && !swi_req && !nmi_req &&
                     !flags_in[IF_BIT] && !flags_in[TF_BIT])); // R4

   AST_LOAD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !busy); // R7

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata))); // R9

endmodule

bind int_entry_seq int_entry_seq_chk #(
   .AW(AW), .DW(DW), .VEC_W(VEC_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT), .NMI_VEC(NMI_VEC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .boundary (boundary),
   .exc_req  (exc_req),
   .swi_req  (swi_req),
   .nmi_req  (nmi_req),
   .flags_in (flags_in),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ack  (mem_ack),
   .busy     (busy),
   .ack      (ack),
   .ack_vec  (ack_vec),
   .load     (load)
);

// File: tb/test_int_entry_seq.sv
module test_int_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary = 1'b0;
   logic        exc_req = 1'b0, swi_req = 1'b0, nmi_req = 1'b0, irq_req = 1'b0, iret_req = 1'b0;
   logic [7:0]  exc_vec = 8'h00, swi_vec = 8'h80, irq_vec = 8'h21;
   logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata = '0;
   logic        busy, ack, load;
   logic [7:0]  ack_vec;
   logic [15:0] new_ip, new_cs, new_flags, new_sp;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   int_entry_seq i_int_entry_seq (
      .clk(clk), .rst_n(rst_n), .boundary(boundary),
      .exc_req(exc_req), .exc_vec(exc_vec), .swi_req(swi_req), .swi_vec(swi_vec),
      .nmi_req(nmi_req), .irq_req(irq_req), .irq_vec(irq_vec), .iret_req(iret_req),
      .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .ack(ack), .ack_vec(ack_vec), .load(load),
      .new_ip(new_ip), .new_cs(new_cs), .new_flags(new_flags), .new_sp(new_sp)
   );

   // memory model and transaction log
   logic [7:0]  mem [logic [19:0]];
   logic        log_we   [16];
   logic [19:0] log_addr [16];
   logic [15:0] log_data [16];
   int          log_n = 0;
   int          hold_err = 0;
   logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
   logic [19:0] p_addr = '0;

   function automatic logic [7:0] rd8(input logic [19:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack)
            mem_rdata <= {rd8(mem_addr + 20'd1), rd8(mem_addr)};
         if (mem_req && mem_ack) begin
            if (log_n < 16) begin
               log_we[log_n]   = mem_we;
               log_addr[log_n] = mem_addr;
               log_data[log_n] = mem_we ? mem_wdata : {rd8(mem_addr + 20'd1), rd8(mem_addr)};
               log_n = log_n + 1;
            end
            if (mem_we) begin
               mem[mem_addr]         = mem_wdata[7:0];
               mem[mem_addr + 20'd1] = mem_wdata[15:8];
            end
         end
         if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we))
            hold_err = hold_err + 1;
      end
      p_req  <= mem_req;
      p_ack  <= mem_ack;
      p_addr <= mem_addr;
      p_we   <= mem_we;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put16(input logic [19:0] a, input logic [15:0] v);
      mem[a]         = v[7:0];
      mem[a + 20'd1] = v[15:8];
   endtask

   // one full sequence; requests withdrawn once busy is seen
   task automatic run_seq(input logic [15:0] fl, input logic e, s, n, i, r,
                          output logic got_ack, output logic [7:0] got_vec);
      @(negedge clk);
      log_n = 0;
      flags_in = fl;
      exc_req = e; swi_req = s; nmi_req = n; irq_req = i; iret_req = r;
      boundary = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
      got_ack = ack;
      got_vec = ack_vec;
      exc_req = 0; swi_req = 0; nmi_req = 0; irq_req = 0; iret_req = 0;
      boundary = 1'b0;
      for (int k = 0; k < 100 && !load; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 load", load, 0);
      chk("R1 ack", ack, 0);
   endtask

   task automatic t_entry();
      logic a; logic [7:0] v;
      put16(20'h00084, 16'h1234);
      put16(20'h00086, 16'h5678);
      ss_in = 16'h3000; sp_in = 16'h0100; cs_in = 16'hABCD; ip_in = 16'h0042;
      run_seq(16'h02C5, 0, 0, 0, 1, 0, a, v);
      chk("R3 irq ack", a, 1);
      chk("R3 irq vec", v, 8'h21);
      chk("R5 count", log_n, 5);
      chk("R5 w0 we", log_we[0], 1);
      chk("R5 w0 addr", log_addr[0], 20'h300FE);
      chk("R5 w0 data", log_data[0], 16'h02C5);
      chk("R5 w1 addr", log_addr[1], 20'h300FC);
      chk("R5 w1 data", log_data[1], 16'hABCD);
      chk("R5 w2 addr", log_addr[2], 20'h300FA);
      chk("R5 w2 data", log_data[2], 16'h0042);
      chk("R5 little-endian low", rd8(20'h300FA), 8'h42);
      chk("R6 r0 addr", {log_we[3], log_addr[3]}, {1'b0, 20'h00084});
      chk("R6 r1 addr", {log_we[4], log_addr[4]}, {1'b0, 20'h00086});
      chk("R7 load", load, 1);
      chk("R7 ip", new_ip, 16'h1234);
      chk("R7 cs", new_cs, 16'h5678);
      chk("R7 flags", new_flags, 16'h00C5);
      chk("R7 sp", new_sp, 16'h00FA);
      @(negedge clk);
      chk("R7 idle after", busy, 0);
      chk("R7 load pulse", load, 0);
   endtask

   task automatic t_iret();
      logic a; logic [7:0] v;
      sp_in = 16'h00FA;
      run_seq(16'h0000, 0, 0, 0, 0, 1, a, v);
      chk("R8 no ack", a, 0);
      chk("R8 count", log_n, 3);
      chk("R8 r0 addr", log_addr[0], 20'h300FA);
      chk("R8 r1 addr", log_addr[1], 20'h300FC);
      chk("R8 r2 addr", log_addr[2], 20'h300FE);
      chk("R8 ip", new_ip, 16'h0042);
      chk("R8 cs", new_cs, 16'hABCD);
      chk("R8 flags", new_flags, 16'h02C5);
      chk("R8 sp", new_sp, 16'h0100);
   endtask

   task automatic t_masked();
      int seen = 0;
      @(negedge clk);
      flags_in = 16'h0000; irq_req = 1'b1; boundary = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (busy || ack || mem_req) seen++;
      end
      irq_req = 1'b0; boundary = 1'b0;
      chk("R4 masked irq ignored", seen, 0);
   endtask

   task automatic t_no_boundary();
      int seen = 0;
      logic a; logic [7:0] v;
      @(negedge clk);
      flags_in = 16'h0200; irq_req = 1'b1; boundary = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (busy || ack || mem_req) seen++;
      end
      irq_req = 1'b0;
      chk("R2 no boundary no accept", seen, 0);
      sp_in = 16'h0100;
      run_seq(16'h0200, 0, 0, 0, 1, 0, a, v);
      chk("R2 accepted at boundary", a, 1);
   endtask

   task automatic t_priority();
      logic a; logic [7:0] v;
      sp_in = 16'h0100;
      run_seq(16'h0200, 1, 1, 1, 1, 0, a, v);
      chk("R3 exc first", v, 8'h00);
      run_seq(16'h0200, 0, 1, 1, 1, 0, a, v);
      chk("R3 swi over nmi", v, 8'h80);
      run_seq(16'h0200, 0, 0, 1, 1, 0, a, v);
      chk("R3 nmi vector 2", v, 8'h02);
      run_seq(16'h0300, 0, 0, 0, 1, 0, a, v);
      chk("R3 irq over trap", v, 8'h21);
      run_seq(16'h0100, 0, 0, 0, 0, 0, a, v);
      chk("R4 trap vector 1", {a, v}, {1'b1, 8'h01});
      run_seq(16'h0385, 0, 0, 0, 1, 0, a, v);
      chk("R7 both flags cleared", new_flags, 16'h0085);
      run_seq(16'h0200, 0, 0, 0, 1, 1, a, v);
      chk("R10 irq beats iret", {a, v}, {1'b1, 8'h21});
      chk("R10 entry writes", log_we[0], 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_entry();
      t_iret();
      t_masked();
      t_no_boundary();
      t_priority();
      chk("R9 request held until ack", hold_err, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule